// File: doc/BRIEF.md
# ASID-Ring Translation Lookaside Buffer

This block translates a virtual address for one instruction fetch, load or store per cycle. It holds a small set-associative array of translation entries. Each entry carries a virtual page number, a physical page number, an address-space identifier (ASID) and a four-bit attribute. A lookup reads one entry from every way, using the low bits of the virtual page number as the index. A way hits when its page number matches and its ASID is both nonzero and present in one byte of a 32-bit ring-map register. The position of that byte gives the entry's privilege ring.

When exactly one way hits, the block compares the ring against the privilege level of the request. It then decodes the attribute into read, write and execute rights. Zero, one or several matching ways each produce their own exception cause, and the cause differs between instruction and data accesses. Every result is registered one cycle after the request. The result also carries the address a page-table walker would read for this virtual address. When the walker returns a page-table entry, the block installs it into the next way of a rotating victim pointer, and the ring field of that entry selects which ASID the new entry receives.

Top module: `asid_ring_tlb`

## Requirements
- R1: After reset the ring map holds 0x04030201, every entry is invalid (any lookup misses) and the victim pointer is 0, so the first refill goes to way 1.
- R2: A lookup reads entry index VA[13:12] of each way. A way hits when its stored page number equals VA[31:12], its ASID is nonzero and that ASID equals some ring-map byte. The ring is the lowest byte index (0..3, byte 0 = bits 7:0) holding that ASID. rsp_hit, rsp_way, rsp_idx and rsp_ring report a single hit.
- R3: An entry whose ASID is 0, or whose ASID appears in no ring-map byte, never hits.
- R4: With no hitting way, rsp_hit is 0 and the cause is 16 for a fetch (lk_kind[1]=1) or 24 for a data access.
- R5: With two or more hitting ways, rsp_hit is 0 and the cause is 17 for a fetch or 25 for a data access.
- R6: On a single hit whose ring is numerically below lk_priv, the cause is 18 for a fetch or 26 for a data access.
- R7: rsp_perm is {execute, write, read}. An attribute below 12 grants read, with bit 0 granting execute and bit 1 granting write. Attribute 13 grants read and write. Any other value grants nothing.
- R8: A request that passes the ring check but lacks its right fails with cause 28 for a load (lk_kind=0), 29 for a store (lk_kind=1) or 20 for a fetch. Otherwise the cause is 0.
- R9: On a single hit, rsp_paddr is the entry's physical page number followed by VA[11:0], and rsp_page_size is 4096. Otherwise both are 0.
- R10: A refill pre-increments the two-bit victim pointer and writes the entry to way pointer+1 at index VA[13:12]. The new entry takes page number VA[31:12], physical page PTE[31:12], attribute PTE[3:0], and the ASID held in the ring-map byte selected by PTE[5:4]. Refill takes precedence over the write port.
- R11: rsp_pt_addr is (pt_base OR (VA >> 10)) with its two low bits cleared.
- R12: rsp_valid is 1 exactly in the cycle after a cycle with lk_valid high. The other response fields hold their values while no lookup is issued.
- R13: A ring-map write changes the ring and the hit status of existing entries from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | 0 load, 1 store, bit 1 set fetch |
| lk_priv | input | 2 | Current privilege index |
| pt_base | input | 32 | Page-table virtual base |
| wr_en | input | 1 | Direct entry write |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 2 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number |
| wr_ppn | input | 20 | Physical page number |
| wr_asid | input | 8 | ASID (0 invalidates) |
| wr_attr | input | 4 | Attribute |
| rasid_we | input | 1 | Ring-map write enable |
| rasid_wdata | input | 32 | New ring-map value |
| refill_en | input | 1 | Install a returned page-table entry |
| refill_vaddr | input | 32 | Virtual address being refilled |
| refill_pte | input | 32 | Page-table entry from the walker |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Exactly one way hit |
| rsp_way | output | 2 | Hitting way |
| rsp_idx | output | 2 | Hitting entry index |
| rsp_ring | output | 2 | Ring of the hitting entry |
| rsp_perm | output | 3 | {execute, write, read} |
| rsp_cause | output | 5 | Exception cause, 0 when granted |
| rsp_paddr | output | 32 | Physical address |
| rsp_page_size | output | 32 | Page size in bytes |
| rsp_pt_addr | output | 32 | Page-table entry address |

## Verification
The assertions check four properties on every cycle. A result follows each request by exactly one cycle. A non-hit never reports anything but a miss or multi-hit cause. A granted access always carries the right its kind needs, and a ring below the privilege level always yields a privilege cause. They also check that the page offset and the page-table address follow the request. Other behaviours depend on stored state, and only the bench scenarios can show them: which way and ring an entry resolves to, the irregular attribute decode, ring-map rewrites changing existing entries, and the rotating victim pointer wrapping across four refills.

// File: rtl/asid_ring_tlb_pkg.sv
package asid_ring_tlb_pkg;
  localparam int VA_W    = 32;
  localparam int PG_BITS = 12;
  localparam int VPN_W   = VA_W - PG_BITS;
  localparam int ASID_W  = 8;
  localparam int RINGS   = 4;
  localparam int ATTR_W  = 4;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] C_OK        = 5'd0;
  localparam logic [CAUSE_W-1:0] C_I_MISS    = 5'd16;
  localparam logic [CAUSE_W-1:0] C_I_MULTI   = 5'd17;
  localparam logic [CAUSE_W-1:0] C_I_PRIV    = 5'd18;
  localparam logic [CAUSE_W-1:0] C_I_DENY    = 5'd20;
  localparam logic [CAUSE_W-1:0] C_D_MISS    = 5'd24;
  localparam logic [CAUSE_W-1:0] C_D_MULTI   = 5'd25;
  localparam logic [CAUSE_W-1:0] C_D_PRIV    = 5'd26;
  localparam logic [CAUSE_W-1:0] C_LD_DENY   = 5'd28;
  localparam logic [CAUSE_W-1:0] C_ST_DENY   = 5'd29;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic [ATTR_W-1:0] attr;
  } tlb_ent_t;

  // rights as {execute, write, read}
  function automatic logic [2:0] attr_rights(input logic [ATTR_W-1:0] a);
    if (a < 4'd12)       return {a[0], a[1], 1'b1};
    else if (a == 4'd13) return 3'b011;
    else                 return 3'b000;
  endfunction
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
  import asid_ring_tlb_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       w_idx,
  input  tlb_ent_t               w_ent,
  input  logic [IDX_W-1:0]       r_idx,
  input  logic [VPN_W-1:0]       r_vpn,
  input  logic [RINGS*ASID_W-1:0] ring_map,
  output logic                   hit,
  output logic [1:0]             ring,
  output tlb_ent_t               r_ent
);
  localparam int DEPTH = 1 << IDX_W;

  tlb_ent_t mem [DEPTH];
  logic     known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i].asid <= '0;
    end else if (we) begin
      mem[w_idx] <= w_ent;
    end
  end

  assign r_ent = mem[r_idx];

  // lowest ring-map byte holding the ASID wins
  always_comb begin
    known = 1'b0;
    ring  = '0;
    for (int b = RINGS - 1; b >= 0; b--) begin
      if (ring_map[b*ASID_W +: ASID_W] == r_ent.asid) begin
        known = 1'b1;
        ring  = 2'(b);
      end
    end
  end

  assign hit = known && (r_ent.asid != '0) && (r_ent.vpn == r_vpn);
endmodule

// File: rtl/tlb_rights_check.sv
module tlb_rights_check
  import asid_ring_tlb_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0]   n_hit,
  input  logic [1:0]         ring,
  input  logic [1:0]         priv,
  input  logic [1:0]         kind,
  input  logic [ATTR_W-1:0]  attr,
  output logic [2:0]         rights,
  output logic [CAUSE_W-1:0] cause
);
  logic fetch, store, allowed;

  assign fetch  = kind[1];
  assign store  = !kind[1] && kind[0];
  assign rights = (n_hit == CNT_W'(1)) ? attr_rights(attr) : 3'b000;
  assign allowed = fetch ? rights[2] : (store ? rights[1] : rights[0]);

  always_comb begin
    if (n_hit == '0)             cause = fetch ? C_I_MISS  : C_D_MISS;
    else if (n_hit > CNT_W'(1))  cause = fetch ? C_I_MULTI : C_D_MULTI;
    else if (ring < priv)        cause = fetch ? C_I_PRIV  : C_D_PRIV;
    else if (!allowed)           cause = fetch ? C_I_DENY  : (store ? C_ST_DENY : C_LD_DENY);
    else                         cause = C_OK;
  end
endmodule

// File: rtl/asid_ring_tlb.sv
module asid_ring_tlb
  import asid_ring_tlb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  logic [31:0]          lk_vaddr,
  input  logic [1:0]           lk_kind,
  input  logic [1:0]           lk_priv,
  input  logic [31:0]          pt_base,
  input  logic                 wr_en,
  input  logic [1:0]           wr_way,
  input  logic [1:0]           wr_idx,
  input  logic [19:0]          wr_vpn,
  input  logic [19:0]          wr_ppn,
  input  logic [7:0]           wr_asid,
  input  logic [3:0]           wr_attr,
  input  logic                 rasid_we,
  input  logic [31:0]          rasid_wdata,
  input  logic                 refill_en,
  input  logic [31:0]          refill_vaddr,
  input  logic [31:0]          refill_pte,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [1:0]           rsp_way,
  output logic [1:0]           rsp_idx,
  output logic [1:0]           rsp_ring,
  output logic [2:0]           rsp_perm,
  output logic [4:0]           rsp_cause,
  output logic [31:0]          rsp_paddr,
  output logic [31:0]          rsp_page_size,
  output logic [31:0]          rsp_pt_addr
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = WAY_W + 1;
  localparam logic [VA_W-1:0] PG_MASK = ~((VA_W'(1) << PG_BITS) - VA_W'(1));
  localparam logic [31:0] RMAP_RST = 32'h0403_0201;

  // ring map and victim pointer
  logic [31:0]      rmap_q, rmap_d;
  logic [WAY_W-1:0] vict_q, vict_d;

  always_comb begin
    rmap_d = rasid_we  ? rasid_wdata : rmap_q;
    vict_d = refill_en ? vict_q + WAY_W'(1) : vict_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rmap_q <= RMAP_RST;
      vict_q <= '0;
    end else begin
      rmap_q <= rmap_d;
      vict_q <= vict_d;
    end
  end

  // write source: refill wins over the direct port
  logic             any_we;
  logic [WAY_W-1:0] w_way;
  logic [IDX_W-1:0] w_idx;
  tlb_ent_t         w_ent;

  always_comb begin
    any_we = refill_en || wr_en;
    if (refill_en) begin
      w_way      = vict_d;
      w_idx      = refill_vaddr[PG_BITS +: IDX_W];
      w_ent.vpn  = refill_vaddr[VA_W-1:PG_BITS];
      w_ent.ppn  = refill_pte[VA_W-1:PG_BITS];
      w_ent.asid = rmap_q[refill_pte[5:4]*ASID_W +: ASID_W];
      w_ent.attr = refill_pte[ATTR_W-1:0];
    end else begin
      w_way      = WAY_W'(wr_way);
      w_idx      = IDX_W'(wr_idx);
      w_ent.vpn  = wr_vpn;
      w_ent.ppn  = wr_ppn;
      w_ent.asid = wr_asid;
      w_ent.attr = wr_attr;
    end
  end

  logic pad_unused;
  assign pad_unused = ^{refill_pte[11:6], refill_vaddr[11:0]};

  // ways
  logic [WAYS-1:0] way_hit;
  logic [1:0]      way_ring [WAYS];
  tlb_ent_t        way_ent  [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way_bank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (any_we && (w_way == WAY_W'(w))),
      .w_idx    (w_idx),
      .w_ent    (w_ent),
      .r_idx    (lk_vaddr[PG_BITS +: IDX_W]),
      .r_vpn    (lk_vaddr[VA_W-1:PG_BITS]),
      .ring_map (rmap_q),
      .hit      (way_hit[w]),
      .ring     (way_ring[w]),
      .r_ent    (way_ent[w])
    );
  end

  // hit count and lowest hitting way
  logic [CNT_W-1:0] n_hit;
  logic [WAY_W-1:0] sel;

  always_comb begin
    n_hit = '0;
    sel   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        n_hit = n_hit + CNT_W'(1);
        sel   = WAY_W'(w);
      end
    end
  end

  logic [2:0]         rights;
  logic [CAUSE_W-1:0] cause;

  tlb_rights_check #(.CNT_W(CNT_W)) u_rights (
    .n_hit  (n_hit),
    .ring   (way_ring[sel]),
    .priv   (lk_priv),
    .kind   (lk_kind),
    .attr   (way_ent[sel].attr),
    .rights (rights),
    .cause  (cause)
  );

  // response next-state
  logic        single;
  logic        hit_d;
  logic [1:0]  way_d, idx_d, ring_d;
  logic [31:0] pa_d, psz_d, pta_d;

  always_comb begin
    single = (n_hit == CNT_W'(1));
    hit_d  = single;
    way_d  = single ? 2'(sel) : 2'd0;
    idx_d  = single ? 2'(lk_vaddr[PG_BITS +: IDX_W]) : 2'd0;
    ring_d = single ? way_ring[sel] : 2'd0;
    pa_d   = single ? ({way_ent[sel].ppn, {PG_BITS{1'b0}}} | (lk_vaddr & ~PG_MASK)) : 32'd0;
    psz_d  = single ? (~PG_MASK + 32'd1) : 32'd0;
    pta_d  = (pt_base | (lk_vaddr >> 10)) & ~32'h3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_idx       <= '0;
      rsp_ring      <= '0;
      rsp_perm      <= '0;
      rsp_cause     <= '0;
      rsp_paddr     <= '0;
      rsp_page_size <= '0;
      rsp_pt_addr   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit       <= hit_d;
        rsp_way       <= way_d;
        rsp_idx       <= idx_d;
        rsp_ring      <= ring_d;
        rsp_perm      <= rights;
        rsp_cause     <= cause;
        rsp_paddr     <= pa_d;
        rsp_page_size <= psz_d;
        rsp_pt_addr   <= pta_d;
      end
    end
  end
endmodule

// File: rtl/asid_ring_tlb_check.sv
module asid_ring_tlb_check (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [31:0] lk_vaddr,
  input logic [1:0]  lk_kind,
  input logic [1:0]  lk_priv,
  input logic [31:0] pt_base,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [1:0]  rsp_ring,
  input logic [2:0]  rsp_perm,
  input logic [4:0]  rsp_cause,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_pt_addr
);
  assert_resp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  assert_nohit_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |->
      (rsp_cause == 5'd16 || rsp_cause == 5'd17 || rsp_cause == 5'd24 || rsp_cause == 5'd25));

  assert_store_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 5'd0 && $past(lk_kind) == 2'd1) |-> rsp_perm[1]);

  assert_fetch_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 5'd0 && $past(lk_kind[1])) |-> rsp_perm[2]);

  assert_priv_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && rsp_ring < $past(lk_priv)) |->
      (rsp_cause == 5'd18 || rsp_cause == 5'd26));

  assert_page_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_paddr[11:0] == $past(lk_vaddr[11:0]));

  assert_pt_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_pt_addr == (($past(pt_base) | ($past(lk_vaddr) >> 10)) & ~32'h3));
endmodule

bind asid_ring_tlb asid_ring_tlb_check u_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_vaddr    (lk_vaddr),
  .lk_kind     (lk_kind),
  .lk_priv     (lk_priv),
  .pt_base     (pt_base),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_ring    (rsp_ring),
  .rsp_perm    (rsp_perm),
  .rsp_cause   (rsp_cause),
  .rsp_paddr   (rsp_paddr),
  .rsp_pt_addr (rsp_pt_addr)
);

// File: tb/asid_ring_tlb_test.sv
`timescale 1ns/1ps
module asid_ring_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind, lk_priv;
  logic [31:0] pt_base;
  logic        wr_en;
  logic [1:0]  wr_way, wr_idx;
  logic [19:0] wr_vpn, wr_ppn;
  logic [7:0]  wr_asid;
  logic [3:0]  wr_attr;
  logic        rasid_we;
  logic [31:0] rasid_wdata;
  logic        refill_en;
  logic [31:0] refill_vaddr, refill_pte;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way, rsp_idx, rsp_ring;
  logic [2:0]  rsp_perm;
  logic [4:0]  rsp_cause;
  logic [31:0] rsp_paddr, rsp_page_size, rsp_pt_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asid_ring_tlb uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] priv);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_priv = priv;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic put(input logic [1:0] way, input logic [1:0] idx, input logic [19:0] vpn,
                     input logic [19:0] ppn, input logic [7:0] asid, input logic [3:0] attr);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_idx = idx; wr_vpn = vpn; wr_ppn = ppn;
    wr_asid = asid; wr_attr = attr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_map(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1'b1; rasid_wdata = v;
    @(negedge clk);
    rasid_we = 1'b0;
  endtask

  task automatic refill(input logic [31:0] va, input logic [31:0] pte);
    @(negedge clk);
    refill_en = 1'b1; refill_vaddr = va; refill_pte = pte;
    @(negedge clk);
    refill_en = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [1:0] way, input logic [1:0] idx,
                            input logic [1:0] ring, input logic [2:0] perm,
                            input logic [4:0] cause, input logic [31:0] pa);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"},   32'(rsp_hit),   32'd1);
    check({req, " way"},   32'(rsp_way),   32'(way));
    check({req, " idx"},   32'(rsp_idx),   32'(idx));
    check({req, " ring"},  32'(rsp_ring),  32'(ring));
    check({req, " perm"},  32'(rsp_perm),  32'(perm));
    check({req, " cause"}, 32'(rsp_cause), 32'(cause));
    check({req, " paddr"}, rsp_paddr, pa);
    check({req, " psize"}, rsp_page_size, 32'd4096);
  endtask

  task automatic expect_nohit(input string req, input logic [4:0] cause);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"},   32'(rsp_hit),   32'd0);
    check({req, " cause"}, 32'(rsp_cause), 32'(cause));
    check({req, " paddr"}, rsp_paddr, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 idle valid", 32'(rsp_valid), 32'd0);
    look(32'h0000_1000, 2'd0, 2'd0); expect_nohit("R1 R4 empty load", 5'd24);
    check("R12 drops", 32'(rsp_valid), 32'd1);
    @(negedge clk); check("R12 one cycle", 32'(rsp_valid), 32'd0);
    check("R12 hold cause", 32'(rsp_cause), 32'd24);
    look(32'h0000_1000, 2'd2, 2'd0); expect_nohit("R4 empty fetch", 5'd16);
  endtask

  task automatic t_basic;
    put(2'd0, 2'd1, 20'h00001, 20'hABCDE, 8'd1, 4'd3);
    look(32'h0000_1234, 2'd0, 2'd0);
    expect_hit("R2 R9 load", 2'd0, 2'd1, 2'd0, 3'b111, 5'd0, 32'hABCD_E234);
    look(32'h0000_1234, 2'd1, 2'd1); check("R6 store priv", 32'(rsp_cause), 32'd26);
    look(32'h0000_1234, 2'd2, 2'd1); check("R6 fetch priv", 32'(rsp_cause), 32'd18);
    look(32'h0000_5234, 2'd0, 2'd0); expect_nohit("R2 other vpn same idx", 5'd24);
  endtask

  task automatic t_multi;
    put(2'd1, 2'd1, 20'h00001, 20'h11111, 8'd2, 4'd3);
    look(32'h0000_1000, 2'd0, 2'd0); expect_nohit("R5 data multi", 5'd25);
    look(32'h0000_1000, 2'd2, 2'd0); expect_nohit("R5 fetch multi", 5'd17);
    put(2'd1, 2'd1, 20'h00001, 20'h11111, 8'd0, 4'd3);
    look(32'h0000_1000, 2'd0, 2'd0);
    expect_hit("R3 asid0 ignored", 2'd0, 2'd1, 2'd0, 3'b111, 5'd0, 32'hABCD_E000);
    put(2'd0, 2'd1, 20'h00001, 20'hABCDE, 8'd9, 4'd3);
    look(32'h0000_1000, 2'd0, 2'd0); expect_nohit("R3 asid not mapped", 5'd24);
    put(2'd0, 2'd1, 20'h00001, 20'hABCDE, 8'd1, 4'd3);
  endtask

  task automatic t_attr;
    put(2'd2, 2'd2, 20'h00002, 20'h00042, 8'd4, 4'd0);
    look(32'h0000_2010, 2'd0, 2'd0);
    expect_hit("R7 attr0 load", 2'd2, 2'd2, 2'd3, 3'b001, 5'd0, 32'h0004_2010);
    look(32'h0000_2010, 2'd1, 2'd0); check("R8 attr0 store", 32'(rsp_cause), 32'd29);
    look(32'h0000_2010, 2'd2, 2'd0); check("R8 attr0 fetch", 32'(rsp_cause), 32'd20);
    put(2'd2, 2'd2, 20'h00002, 20'h00042, 8'd4, 4'd13);
    look(32'h0000_2010, 2'd1, 2'd3);
    expect_hit("R7 attr13 store", 2'd2, 2'd2, 2'd3, 3'b011, 5'd0, 32'h0004_2010);
    look(32'h0000_2010, 2'd2, 2'd0); check("R8 attr13 fetch", 32'(rsp_cause), 32'd20);
    put(2'd2, 2'd2, 20'h00002, 20'h00042, 8'd4, 4'd5);
    look(32'h0000_2010, 2'd2, 2'd0);
    expect_hit("R7 attr5 fetch", 2'd2, 2'd2, 2'd3, 3'b101, 5'd0, 32'h0004_2010);
    look(32'h0000_2010, 2'd1, 2'd0); check("R8 attr5 store", 32'(rsp_cause), 32'd29);
    put(2'd2, 2'd2, 20'h00002, 20'h00042, 8'd4, 4'd12);
    look(32'h0000_2010, 2'd0, 2'd0);
    check("R7 attr12 perm", 32'(rsp_perm), 32'd0);
    check("R8 attr12 load", 32'(rsp_cause), 32'd28);
    put(2'd2, 2'd2, 20'h00002, 20'h00042, 8'd4, 4'd14);
    look(32'h0000_2010, 2'd0, 2'd0);
    check("R7 attr14 perm", 32'(rsp_perm), 32'd0);
    check("R8 attr14 load", 32'(rsp_cause), 32'd28);
  endtask

  task automatic t_ringmap;
    put(2'd2, 2'd2, 20'h00002, 20'h00042, 8'd4, 4'd3);
    set_map(32'h0102_0304);
    look(32'h0000_2000, 2'd0, 2'd3);
    check("R13 new ring", 32'(rsp_ring), 32'd0);
    check("R13 priv cause", 32'(rsp_cause), 32'd26);
    set_map(32'h0404_0404);
    look(32'h0000_2000, 2'd0, 2'd0);
    expect_hit("R2 lowest byte", 2'd2, 2'd2, 2'd0, 3'b111, 5'd0, 32'h0004_2000);
    look(32'h0000_1000, 2'd0, 2'd0); expect_nohit("R13 unmapped asid", 5'd24);
    set_map(32'h0403_0201);
  endtask

  task automatic t_refill;
    pt_base = 32'hC000_0000;
    look(32'h0040_3123, 2'd0, 2'd0);
    expect_nohit("R4 before refill", 5'd24);
    check("R11 pt addr", rsp_pt_addr, 32'hC000_100C);
    pt_base = 32'h8000_0003;
    look(32'h0000_0FFF, 2'd0, 2'd0);
    check("R11 low bits cleared", rsp_pt_addr, 32'h8000_0000);
    refill(32'h0040_3123, 32'h1234_5023);
    look(32'h0040_3123, 2'd0, 2'd0);
    expect_hit("R10 first refill", 2'd1, 2'd3, 2'd2, 3'b111, 5'd0, 32'h1234_5123);
    refill(32'h0050_0000, 32'h0000_7013);
    look(32'h0050_0ABC, 2'd0, 2'd0);
    expect_hit("R10 second refill", 2'd2, 2'd0, 2'd1, 3'b111, 5'd0, 32'h0000_7ABC);
    refill(32'h0060_0000, 32'h0000_8003);
    look(32'h0060_0004, 2'd0, 2'd0);
    expect_hit("R10 third refill", 2'd3, 2'd0, 2'd0, 3'b111, 5'd0, 32'h0000_8004);
    @(negedge clk);
    wr_en = 1'b1; wr_way = 2'd1; wr_idx = 2'd2; wr_vpn = 20'h00902; wr_ppn = 20'h0;
    wr_asid = 8'd1; wr_attr = 4'd3;
    refill_en = 1'b1; refill_vaddr = 32'h0070_0000; refill_pte = 32'h0000_9033;
    @(negedge clk);
    wr_en = 1'b0; refill_en = 1'b0;
    look(32'h0070_0008, 2'd0, 2'd3);
    expect_hit("R10 wrap to way0", 2'd0, 2'd0, 2'd3, 3'b111, 5'd0, 32'h0000_9008);
    look(32'h0090_2000, 2'd0, 2'd0); expect_nohit("R10 refill over write", 5'd24);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0; lk_kind = '0; lk_priv = '0;
    pt_base = '0; wr_en = 1'b0; wr_way = '0; wr_idx = '0; wr_vpn = '0; wr_ppn = '0;
    wr_asid = '0; wr_attr = '0; rasid_we = 1'b0; rasid_wdata = '0;
    refill_en = 1'b0; refill_vaddr = '0; refill_pte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_multi();
    t_attr();
    t_ringmap();
    t_refill();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule